// File: doc/BRIEF.md
# DDR Read Data Capture Path

This block takes read data from a double-data-rate memory bus and delivers it as word pairs in the system clock domain. A PLL-generated capture clock samples every DQ line twice per period: once on its rising edge and once on its falling edge. The memory's read strobe is not used, so no postamble gating is needed. The falling-edge sample is moved back onto the rising edge. It is then paired with the rising-edge sample of the same beat, passed through a stage of sync registers, and written as one entry into a small asynchronous FIFO with Gray-coded pointers.

A read-valid input on the capture clock marks the beats that belong to a read burst. Only those beats are pushed, and all other beats are dropped. On the system side the FIFO drains one pair per clock whenever it holds data. Each pair appears with a one-cycle valid pulse: the rising-edge word comes out on the high output and the falling-edge word on the low output. If the FIFO is full when a pair arrives, that pair is dropped and stored data is never overwritten. A sticky error flag is then raised and brought into the system domain.

The bus width is `BYTES*(8+PAR_EN)`, so 8, 16 or 32 bit groups, or 9, 18 and 36 bit groups with one parity bit per byte. Parity bits are handled exactly like data bits.

Top module: `ddr_rd_capture`

## Requirements
- R1: For an accepted beat, `data_hi_o` carries the DQ value sampled on the capture-clock rising edge and `data_lo_o` carries the value sampled on the following falling edge. Both appear in the same `valid_o` cycle.
- R2: Every bit of `dq_i`, including the ninth (parity) bit of each byte when `PAR_EN=1`, is passed unmodified. The bench drives values that use bit 8 and checks it on both outputs.
- R3: A beat is pushed only when `rd_valid_i` is high at the capture-clock rising edge that samples its rising word. Beats with `rd_valid_i` low never appear on the outputs.
- R4: Accepted pairs leave in the order in which they were captured, with no pair lost or duplicated while the FIFO does not overflow.
- R5: A pair that arrives while the FIFO is full is dropped. Stored pairs are never overwritten, so the pairs that are delivered remain an in-order subset of those sent, and the first `2**AW` pairs of the burst are kept. `ovf_o` then goes high.
- R6: `ovf_o` stays high once set, until reset.
- R7: `valid_o` is high for exactly one system clock per delivered pair. The FIFO drains at one pair per system clock while it is non-empty.
- R8: After reset, `valid_o` and `ovf_o` are low and the FIFO is empty.
- R9: The first pair of a burst into an empty FIFO appears on `valid_o` within 6 system clock cycles after its rising-edge sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk_i | input | 1 | PLL capture clock; both edges sample DQ |
| sys_clk_i | input | 1 | System clock for the output side |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| rd_valid_i | input | 1 | Capture-clock beat qualifier; high marks a read-burst beat |
| dq_i | input | BYTES*(8+PAR_EN) | DDR read data bus |
| data_hi_o | output | BYTES*(8+PAR_EN) | Rising-edge word of the delivered pair |
| data_lo_o | output | BYTES*(8+PAR_EN) | Falling-edge word of the delivered pair |
| valid_o | output | 1 | One-cycle pulse per delivered pair |
| ovf_o | output | 1 | Sticky FIFO overflow flag, system domain |

## Verification
On the capture side a beat takes three capture-clock edges to reach the FIFO write: one for the A and B registers, one for realignment, and one for the sync stage. The Gray pointer then needs two system clock edges to cross, and one more edge loads the output register. The bench therefore checks only a bound of 6 system cycles on first-pair latency and does not assume an exact arrival cycle. It compares every delivered pair against a queue of expected pairs, sampling on system clock falling edges; in the overflow phase it accepts any in-order subset of what was sent. The overflow flag is checked after a settling delay of several system cycles, because it is synchronized with two flops.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  localparam int unsigned DEF_BYTES  = 1;
  localparam int unsigned DEF_PAR_EN = 1;
  localparam int unsigned DEF_AW     = 3;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/ddr_cap_sync.sv
module ddr_cap_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ddr_cap_lane.sv
module ddr_cap_lane #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] dq_i,
  input  logic         rd_valid_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         push_o
);
  logic [W-1:0] a_q, b_q, c_q;
  logic [W-1:0] hi_al_q, sync_h_q, sync_l_q;
  logic         v1_q, v2_q, sync_v_q;

  // per-bit capture: A rising, B falling, C realigns B to rising
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) a_q[i] <= 1'b0;
      else         a_q[i] <= dq_i[i];
    end
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) b_q[i] <= 1'b0;
      else         b_q[i] <= dq_i[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) c_q[i] <= 1'b0;
      else         c_q[i] <= b_q[i];
    end
  end

  // hold rising word one cycle so it pairs with the later falling word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_al_q  <= '0;
      sync_h_q <= '0;
      sync_l_q <= '0;
      v1_q     <= 1'b0;
      v2_q     <= 1'b0;
      sync_v_q <= 1'b0;
    end else begin
      hi_al_q  <= a_q;
      v1_q     <= rd_valid_i;
      v2_q     <= v1_q;
      sync_h_q <= hi_al_q;
      sync_l_q <= c_q;
      sync_v_q <= v2_q;
    end
  end

  assign hi_o   = sync_h_q;
  assign lo_o   = sync_l_q;
  assign push_o = sync_v_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  a_r3_push_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && push_o) |-> $past(rd_valid_i, 3));
  a_r3_no_push_without_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && !$past(rd_valid_i, 3)) |-> !push_o);
endmodule

// File: rtl/ddr_cap_afifo.sv
module ddr_cap_afifo
  import ddr_cap_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 3
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          ovf_o,
  output logic          rd_vld_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt;
  logic [PW-1:0] rq2, wq2;
  logic          full, empty, wr_en, ovf_q;

  // write domain
  assign full     = (wgray_q == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign wr_en    = wr_req_i & ~full;
  assign wbin_nxt = wbin_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (wr_req_i && full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge wclk_i) begin
    if (wr_en) mem[wbin_q[AW-1:0]] <= wr_data_i;
  end

  assign ovf_o = ovf_q;

  ddr_cap_sync #(.W(PW), .STAGES(SYNC_DEPTH)) u_rptr_sync (
    .clk_i (wclk_i), .rst_ni (rst_ni), .d_i (rgray_q), .q_o (rq2)
  );

  // read domain
  assign empty    = (rgray_q == wq2);
  assign rbin_nxt = rbin_q + PW'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q    <= '0;
      rgray_q   <= '0;
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
    end else begin
      rd_vld_o <= ~empty;
      if (!empty) begin
        rd_data_o <= mem[rbin_q[AW-1:0]];
        rbin_q    <= rbin_nxt;
        rgray_q   <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end
  end

  ddr_cap_sync #(.W(PW), .STAGES(SYNC_DEPTH)) u_wptr_sync (
    .clk_i (rclk_i), .rst_ni (rst_ni), .d_i (wgray_q), .q_o (wq2)
  );

  // occupancy seen from the write side never exceeds DEPTH
  logic [PW-1:0] rbin_w, occ_w;
  always_comb begin
    rbin_w[PW-1] = rq2[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_w[i] = rbin_w[i+1] ^ rq2[i];
    occ_w = wbin_q - rbin_w;
  end

  a_r5_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    occ_w <= PW'(DEPTH));
  a_r5_full_holds_wptr: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full |=> (wbin_q == $past(wbin_q)));
  a_r6_ovf_sticky: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
  a_r4_wgray_step: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wgray_q ^ $past(wgray_q)));
  a_r4_rgray_step: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/ddr_rd_capture.sv
module ddr_rd_capture
  import ddr_cap_pkg::*;
#(
  parameter int unsigned BYTES  = DEF_BYTES,
  parameter int unsigned PAR_EN = DEF_PAR_EN,
  parameter int unsigned AW     = DEF_AW,
  localparam int unsigned DQ_W  = BYTES * (8 + PAR_EN)
) (
  input  logic            cap_clk_i,
  input  logic            sys_clk_i,
  input  logic            rst_ni,
  input  logic            rd_valid_i,
  input  logic [DQ_W-1:0] dq_i,
  output logic [DQ_W-1:0] data_hi_o,
  output logic [DQ_W-1:0] data_lo_o,
  output logic            valid_o,
  output logic            ovf_o
);
  logic [DQ_W-1:0]   cap_hi, cap_lo;
  logic              cap_push, ovf_cap, ovf_sys;
  logic [2*DQ_W-1:0] rd_data;

  ddr_cap_lane #(.W(DQ_W)) u_lane (
    .clk_i      (cap_clk_i),
    .rst_ni     (rst_ni),
    .dq_i       (dq_i),
    .rd_valid_i (rd_valid_i),
    .hi_o       (cap_hi),
    .lo_o       (cap_lo),
    .push_o     (cap_push)
  );

  ddr_cap_afifo #(.DW(2*DQ_W), .AW(AW)) u_fifo (
    .wclk_i    (cap_clk_i),
    .rclk_i    (sys_clk_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (cap_push),
    .wr_data_i ({cap_hi, cap_lo}),
    .ovf_o     (ovf_cap),
    .rd_vld_o  (valid_o),
    .rd_data_o (rd_data)
  );

  ddr_cap_sync #(.W(1), .STAGES(SYNC_DEPTH)) u_ovf_sync (
    .clk_i (sys_clk_i), .rst_ni (rst_ni), .d_i (ovf_cap), .q_o (ovf_sys)
  );

  assign data_hi_o = rd_data[2*DQ_W-1:DQ_W];
  assign data_lo_o = rd_data[DQ_W-1:0];
  assign ovf_o     = ovf_sys;

  a_r6_ovf_o_sticky: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
endmodule

// File: tb/ddr_rd_capture_bench.sv
`timescale 1ns/1ps
module ddr_rd_capture_bench;
  localparam int W = 9;

  logic cap_clk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic rd_valid = 1'b0;
  logic [W-1:0] dq = '0;
  logic [W-1:0] hi, lo;
  logic vld, ovf;

  int n_run = 0, n_fail = 0;
  logic [2*W-1:0] exp_q [$];
  bit mon_en = 0, subseq = 0;
  int n_out = 0;
  bit lat_arm = 0;
  int lat_cnt = 0, lat_seen = -1;
  bit finished = 0;

  initial begin #3; forever #5 cap_clk = ~cap_clk; end
  always #10 sys_clk = ~sys_clk;

  ddr_rd_capture u_ddr_rd_capture (
    .cap_clk_i (cap_clk), .sys_clk_i (sys_clk), .rst_ni (rst_n),
    .rd_valid_i (rd_valid), .dq_i (dq),
    .data_hi_o (hi), .data_lo_o (lo), .valid_o (vld), .ovf_o (ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // reference model: queue of expected pairs, compared on every system clock
  always @(negedge sys_clk) begin
    if (lat_arm) begin
      lat_cnt++;
      if (vld) begin lat_seen = lat_cnt; lat_arm = 0; end
    end
    if (mon_en && vld) begin
      n_out++;
      if (!subseq) begin
        if (exp_q.size() == 0) chk(0, "R3 unexpected pair", int'({hi, lo}), 0);
        else begin
          logic [2*W-1:0] e;
          e = exp_q.pop_front();
          chk(hi == e[2*W-1:W], "R1 R2 R4 high word", int'(hi), int'(e[2*W-1:W]));
          chk(lo == e[W-1:0], "R1 R2 R4 low word", int'(lo), int'(e[W-1:0]));
        end
      end else begin
        bit hit = 0;
        while (exp_q.size() > 0 && !hit) begin
          logic [2*W-1:0] e;
          e = exp_q.pop_front();
          if (e == {hi, lo}) hit = 1;
        end
        chk(hit, "R5 delivered pair not in order subset", int'({hi, lo}), 0);
      end
    end
  end

  task automatic beat(input logic [W-1:0] r, input logic [W-1:0] f, input bit v, input bit arm);
    @(negedge cap_clk); #2;
    dq = r; rd_valid = v;
    @(posedge cap_clk); #2;
    dq = f;
    if (v) exp_q.push_back({r, f});
    if (arm) begin lat_cnt = 0; lat_seen = -1; lat_arm = 1; end
  endtask

  task automatic idle(input int n);
    @(negedge cap_clk); #2; rd_valid = 0;
    repeat (n) @(posedge sys_clk);
  endtask

  initial begin
    #47 rst_n = 1'b1;
    repeat (3) @(posedge sys_clk);
    #3;
    // R8 reset state
    chk(vld == 1'b0, "R8 valid_o after reset", int'(vld), 0);
    chk(ovf == 1'b0, "R8 ovf_o after reset", int'(ovf), 0);
    mon_en = 1;
    idle(10);
    chk(n_out == 0, "R8 FIFO empty after reset", n_out, 0);

    // R1 R2 R9 short burst, parity bit used
    for (int i = 0; i < 4; i++)
      beat(W'(9'h100 | (i * 37 + 5)), W'(9'h0AA ^ (i * 91)), 1'b1, i == 0);
    idle(12);
    chk(lat_seen > 0 && lat_seen <= 6, "R9 first pair latency", lat_seen, 6);
    chk(exp_q.size() == 0, "R4 burst fully delivered", exp_q.size(), 0);
    chk(n_out == 4, "R7 one valid pulse per pair", n_out, 4);

    // R3 interleaved valid / invalid beats
    n_out = 0;
    for (int i = 0; i < 10; i++)
      beat(W'(i * 53 + 1), W'(9'h1FF - i * 29), (i % 3) != 1, 1'b0);
    idle(14);
    chk(exp_q.size() == 0, "R3 qualified beats delivered", exp_q.size(), 0);
    chk(n_out == 7, "R3 unqualified beats dropped", n_out, 7);

    // R3 all beats unqualified
    n_out = 0;
    for (int i = 0; i < 6; i++) beat(W'(9'h155), W'(9'h0AA), 1'b0, 1'b0);
    idle(10);
    chk(n_out == 0, "R3 no output for rd_valid low", n_out, 0);

    // R1 extremes and single-beat bursts
    n_out = 0;
    beat(W'(9'h1FF), W'(9'h000), 1'b1, 1'b0);
    idle(6);
    beat(W'(9'h000), W'(9'h1FF), 1'b1, 1'b0);
    idle(6);
    beat(W'(9'h100), W'(9'h100), 1'b1, 1'b0);
    idle(10);
    chk(n_out == 3, "R7 single-beat pairs", n_out, 3);
    chk(ovf == 1'b0, "R5 no overflow yet", int'(ovf), 0);

    // R5 overflow: capture runs at twice the drain rate
    n_out = 0;
    subseq = 1;
    for (int i = 0; i < 40; i++) beat(W'(i * 11 + 3), W'(i * 7 + 200), 1'b1, 1'b0);
    idle(40);
    chk(ovf == 1'b1, "R5 ovf_o set on overflow", int'(ovf), 1);
    chk(n_out >= 8 && n_out < 40, "R5 pairs dropped not overwritten", n_out, 8);
    exp_q.delete();
    subseq = 0;

    // R6 sticky, FIFO still correct afterwards
    n_out = 0;
    for (int i = 0; i < 3; i++) beat(W'(9'h0F0 + i), W'(9'h10F - i), 1'b1, 1'b0);
    idle(14);
    chk(exp_q.size() == 0 && n_out == 3, "R4 recovery after overflow", n_out, 3);
    chk(ovf == 1'b1, "R6 ovf_o stays set", int'(ovf), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule